// File: doc/BRIEF.md
# Unified TLB Address Translator

This block turns a 32-bit virtual address into a physical address, or into a fault code, for a processor core. Each request carries the address, a write flag and a privilege flag. The block first sorts the address by region. Privileged accesses to the top regions pass straight through. A narrow window of the top region is open to user code. When translation is off, everything else is cut down to 29 bits. The remaining accesses search a fully associative table of up to 64 page entries. The search matches on a valid bit, an address-space identifier and the page number under the entry's page size.

A hit is then checked against the entry's user, writable and dirty flags. The result is registered, so the answer appears one cycle after the request. A fault raised by the table stores the faulting address. It also overwrites the upper part of the staging-high register, so that software can see which page to refill. Software writes the staging-high and staging-low registers, then issues a load command. The load places the entry at the slot named by a replacement pointer. That pointer advances on every table search and wraps at a programmable boundary.

Top module: `xlat_tlb`

## Requirements
- R1: A privileged request with bit 31 set returns its address unchanged when the address is at or above 0xE0000000. It returns the address with bits 31:29 cleared when the address is below 0xC0000000. In both cases the fault code is 0. A privileged request from 0xC0000000 to 0xDFFFFFFF is handled like a low address.
- R2: A user request with bit 31 set returns its address unchanged only when the address lies in 0xE0000000..0xE3FFFFFF and `cfg_sq_lock` is 0. Otherwise it faults with code 1 for a read or code 2 for a write, and the table is not searched.
- R3: When `cfg_xlat_en` is 0, every request not handled by R1 or R2 returns its address with bits 31:29 cleared and fault code 0.
- R4: An entry matches when three things hold: its valid flag (bit 8) is set; its shared flag (bit 1) is set or its ASID equals `stage_hi[7:0]`; and its page number equals the address under its page mask. The ASID test is skipped when `cfg_single_virt` is 1 and the request is privileged.
- R5: The page size is set by flag bits {7,4}: 00 gives 1 KB, 01 gives 4 KB, 10 gives 64 KB and 11 gives 1 MB. On a clean hit the physical address takes the page frame bits inside the mask and the virtual address bits outside it.
- R6: The protection rules are as follows. A user read needs the user flag (bit 6). A privileged write needs the writable flag (bit 5). A user write needs both flags. Breaking a rule faults with code 5 for a read or code 6 for a write.
- R7: A write that passes protection to an entry whose dirty flag (bit 2) is clear faults with code 7.
- R8: No matching entry faults with code 3 for a read or code 4 for a write. Two or more matching entries fault with code 8, whatever the direction.
- R9: On any fault with code 3 to 8, `fault_addr` takes the request address. `stage_hi[31:10]` also takes address bits 31:10, while `stage_hi[9:0]` keeps its value. Codes 0 to 2 change neither register.
- R10: `repl_ptr` advances by one on every table search. It returns to 0 when the incremented value equals `cfg_wrap` or equals the entry count. It holds when there is no search.
- R11: `load_cmd` writes the slot named by `repl_ptr` from the staging registers. The page number comes from `stage_hi[31:10]` and the ASID from `stage_hi[7:0]`. The frame comes from `stage_lo[28:10]` and the flags from `stage_lo[8:0]`. Bits 31:29 of `stage_lo` are ignored.
- R12: `rsp_valid` is high exactly one cycle after each `req_valid`, and `rsp_paddr` and `rsp_fault` hold that request's result. A faulting response shows `rsp_paddr` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged request |
| cfg_xlat_en | input | 1 | Translation enable |
| cfg_single_virt | input | 1 | Privileged requests ignore the ASID |
| cfg_sq_lock | input | 1 | Closes the user window at the top of the space |
| cfg_wrap | input | IDX_W | Replacement pointer wrap boundary |
| hi_we | input | 1 | Write enable for staging-high |
| hi_wdata | input | 32 | Staging-high write data |
| lo_we | input | 1 | Write enable for staging-low |
| lo_wdata | input | 32 | Staging-low write data |
| load_cmd | input | 1 | Copy the staging registers into the slot at `repl_ptr` |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 4 | Fault code (0 = none) |
| fault_addr | output | 32 | Address of the last table fault |
| stage_hi | output | 32 | Staging-high register; bits 7:0 hold the current ASID |
| repl_ptr | output | IDX_W | Replacement pointer |

## Verification
The hardest case to reach from the ports is a multi-hit. The load path places entries only at the replacement pointer, so two entries that cover the same page must land in different slots. The stimulus therefore issues throw-away missing searches between loads, which steps the pointer and lays out a known table with a duplicated page. A second hard case is the pointer wrap. It is reached by long runs of missing searches, first against a small programmed boundary and then against the entry count.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  typedef enum logic [3:0] {
    FLT_NONE     = 4'd0,
    FLT_ADDR_RD  = 4'd1,
    FLT_ADDR_WR  = 4'd2,
    FLT_MISS_RD  = 4'd3,
    FLT_MISS_WR  = 4'd4,
    FLT_PROT_RD  = 4'd5,
    FLT_PROT_WR  = 4'd6,
    FLT_FIRST_WR = 4'd7,
    FLT_MULTI    = 4'd8
  } tlbx_fault_e;

  typedef enum logic [1:0] {
    RT_RAW,
    RT_LOW29,
    RT_BADADDR,
    RT_LOOKUP
  } tlbx_route_e;

  localparam int FL_SHARE = 1;
  localparam int FL_DIRTY = 2;
  localparam int FL_SZ_LO = 4;
  localparam int FL_WR    = 5;
  localparam int FL_USER  = 6;
  localparam int FL_SZ_HI = 7;
  localparam int FL_VALID = 8;

  // page mask selected by the two size flags
  function automatic logic [31:0] page_mask(input logic [8:0] fl);
    case ({fl[FL_SZ_HI], fl[FL_SZ_LO]})
      2'b00:   return 32'hFFFF_FC00;
      2'b01:   return 32'hFFFF_F000;
      2'b10:   return 32'hFFFF_0000;
      default: return 32'hFFF0_0000;
    endcase
  endfunction

  function automatic logic [31:0] low29(input logic [31:0] a);
    return {3'b000, a[28:0]};
  endfunction

  function automatic logic [31:0] splice(input logic [31:0] frame,
                                         input logic [31:0] mask,
                                         input logic [31:0] va);
    return (frame & mask) | (va & ~mask);
  endfunction

  // region decode ahead of any table search
  function automatic tlbx_route_e classify(input logic [31:0] va,
                                           input logic priv,
                                           input logic sq_lock,
                                           input logic xlat_en);
    if (va[31] && priv && va[31:29] == 3'b111) return RT_RAW;
    if (va[31] && priv && va[31:30] == 2'b10)  return RT_LOW29;
    if (va[31] && !priv) begin
      if (va[31:26] == 6'b111000 && !sq_lock) return RT_RAW;
      return RT_BADADDR;
    end
    if (!xlat_en) return RT_LOW29;
    return RT_LOOKUP;
  endfunction

  function automatic logic is_tlb_fault(input tlbx_fault_e f);
    return f >= FLT_MISS_RD;
  endfunction

endpackage

// File: rtl/tlbx_entry_bank.sv
module tlbx_entry_bank
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [21:0]        wr_vpn,
  input  logic [7:0]         wr_asid,
  input  logic [18:0]        wr_ppn,
  input  logic [8:0]         wr_flags,
  input  logic [31:0]        lk_va,
  input  logic [7:0]         lk_asid,
  input  logic               lk_any_asid,
  output logic [ENTRIES-1:0] match_vec,
  output logic [18:0]        hit_ppn,
  output logic [8:0]         hit_flags
);

  logic [18:0] ppn_a   [ENTRIES];
  logic [8:0]  flags_a [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic [21:0] vpn_q;
    logic [7:0]  asid_q;
    logic [18:0] ppn_q;
    logic [8:0]  flags_q;
    logic        sel;

    assign sel = wr_en && (int'(wr_idx) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flags_q <= '0;
      else if (sel) flags_q <= wr_flags;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        vpn_q  <= wr_vpn;
        asid_q <= wr_asid;
        ppn_q  <= wr_ppn;
      end
    end

    assign match_vec[g] = flags_q[FL_VALID]
                       && (flags_q[FL_SHARE] || lk_any_asid || asid_q == lk_asid)
                       && ((({vpn_q, 10'b0}) ^ lk_va) & page_mask(flags_q)) == 32'h0;
    assign ppn_a[g]   = ppn_q;
    assign flags_a[g] = flags_q;
  end

  // OR of the matching slots; exact whenever a single slot matches
  always_comb begin
    hit_ppn   = '0;
    hit_flags = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        hit_ppn   = hit_ppn | ppn_a[i];
        hit_flags = hit_flags | flags_a[i];
      end
    end
  end

endmodule

// File: rtl/tlbx_repl_ctr.sv
module tlbx_repl_ctr #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] wrap_at,
  output logic [IDX_W-1:0] ptr
);

  logic [IDX_W:0] nxt;
  logic           wrap_hit;

  assign nxt      = {1'b0, ptr} + 1'b1;
  assign wrap_hit = (nxt == {1'b0, wrap_at}) || (nxt == (IDX_W+1)'(ENTRIES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (step) ptr <= wrap_hit ? '0 : nxt[IDX_W-1:0];
  end

  p_ptr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < ENTRIES);

  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr));

  p_ptr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (ptr == '0 || ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  input  logic             req_write,
  input  logic             req_priv,
  input  logic             cfg_xlat_en,
  input  logic             cfg_single_virt,
  input  logic             cfg_sq_lock,
  input  logic [IDX_W-1:0] cfg_wrap,
  input  logic             hi_we,
  input  logic [31:0]      hi_wdata,
  input  logic             lo_we,
  input  logic [31:0]      lo_wdata,
  input  logic             load_cmd,
  output logic             rsp_valid,
  output logic [31:0]      rsp_paddr,
  output logic [3:0]       rsp_fault,
  output logic [31:0]      fault_addr,
  output logic [31:0]      stage_hi,
  output logic [IDX_W-1:0] repl_ptr
);

  tlbx_route_e        rt;
  logic               lookup_fire;
  logic               any_asid;
  logic [ENTRIES-1:0] match_vec;
  logic [18:0]        hit_ppn;
  logic [8:0]         hit_flags;
  int                 hit_cnt;
  logic               prot_bad;
  tlbx_fault_e        fault_next;
  logic [31:0]        paddr_next;
  logic               tlb_fault_now;
  logic [31:0]        stage_lo;
  tlbx_fault_e        rsp_fault_q;

  assign rt          = classify(req_vaddr, req_priv, cfg_sq_lock, cfg_xlat_en);
  assign lookup_fire = req_valid && (rt == RT_LOOKUP);
  assign any_asid    = cfg_single_virt && req_priv;

  tlbx_entry_bank #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (load_cmd),
    .wr_idx      (repl_ptr),
    .wr_vpn      (stage_hi[31:10]),
    .wr_asid     (stage_hi[7:0]),
    .wr_ppn      (stage_lo[28:10]),
    .wr_flags    (stage_lo[8:0]),
    .lk_va       (req_vaddr),
    .lk_asid     (stage_hi[7:0]),
    .lk_any_asid (any_asid),
    .match_vec   (match_vec),
    .hit_ppn     (hit_ppn),
    .hit_flags   (hit_flags)
  );

  tlbx_repl_ctr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (lookup_fire),
    .wrap_at (cfg_wrap),
    .ptr     (repl_ptr)
  );

  assign hit_cnt = $countones(match_vec);

  always_comb begin
    if (req_write)
      prot_bad = req_priv ? !hit_flags[FL_WR] : !(hit_flags[FL_WR] && hit_flags[FL_USER]);
    else
      prot_bad = !req_priv && !hit_flags[FL_USER];
  end

  always_comb begin
    fault_next = FLT_NONE;
    paddr_next = '0;
    case (rt)
      RT_RAW:     paddr_next = req_vaddr;
      RT_LOW29:   paddr_next = low29(req_vaddr);
      RT_BADADDR: fault_next = req_write ? FLT_ADDR_WR : FLT_ADDR_RD;
      default: begin
        if (hit_cnt == 0)                       fault_next = req_write ? FLT_MISS_WR : FLT_MISS_RD;
        else if (hit_cnt > 1)                   fault_next = FLT_MULTI;
        else if (prot_bad)                      fault_next = req_write ? FLT_PROT_WR : FLT_PROT_RD;
        else if (req_write && !hit_flags[FL_DIRTY]) fault_next = FLT_FIRST_WR;
        else paddr_next = splice({3'b000, hit_ppn, 10'b0}, page_mask(hit_flags), req_vaddr);
      end
    endcase
  end

  assign tlb_fault_now = req_valid && is_tlb_fault(fault_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_fault_q <= FLT_NONE;
      fault_addr  <= '0;
      stage_hi    <= '0;
      stage_lo    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr   <= paddr_next;
        rsp_fault_q <= fault_next;
      end
      if (tlb_fault_now) fault_addr <= req_vaddr;
      if (hi_we)              stage_hi <= hi_wdata;
      else if (tlb_fault_now) stage_hi <= {req_vaddr[31:10], stage_hi[9:0]};
      if (lo_we) stage_lo <= lo_wdata;
    end
  end

  assign rsp_fault = rsp_fault_q;

  p_rsp_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_fault_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && is_tlb_fault(rsp_fault_q)) |-> fault_addr == $past(req_vaddr));

  p_hi_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && is_tlb_fault(rsp_fault_q) && !$past(hi_we))
      |-> stage_hi[9:0] == $past(stage_hi[9:0]));

  p_multi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_fire && hit_cnt > 1) |=> rsp_fault_q == FLT_MULTI);

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cfg_xlat_en && !req_vaddr[31])
      |=> (rsp_paddr == {3'b000, $past(req_vaddr[28:0])} && rsp_fault_q == FLT_NONE));

endmodule

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;

  localparam int N  = 64;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_vaddr = '0;
  logic          req_write = 1'b0;
  logic          req_priv = 1'b0;
  logic          cfg_xlat_en = 1'b0;
  logic          cfg_single_virt = 1'b0;
  logic          cfg_sq_lock = 1'b0;
  logic [IW-1:0] cfg_wrap = '0;
  logic          hi_we = 1'b0;
  logic [31:0]   hi_wdata = '0;
  logic          lo_we = 1'b0;
  logic [31:0]   lo_wdata = '0;
  logic          load_cmd = 1'b0;
  logic          rsp_valid;
  logic [31:0]   rsp_paddr;
  logic [3:0]    rsp_fault;
  logic [31:0]   fault_addr;
  logic [31:0]   stage_hi;
  logic [IW-1:0] repl_ptr;

  // 250 MHz: 4 ns period
  always #2 clk = ~clk;

  xlat_tlb #(.ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_priv(req_priv), .cfg_xlat_en(cfg_xlat_en),
    .cfg_single_virt(cfg_single_virt), .cfg_sq_lock(cfg_sq_lock), .cfg_wrap(cfg_wrap),
    .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
    .load_cmd(load_cmd), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .fault_addr(fault_addr), .stage_hi(stage_hi),
    .repl_ptr(repl_ptr)
  );

  typedef struct {
    logic [31:0] pa;
    logic [3:0]  flt;
    logic [31:0] fa;
    logic [31:0] shi;
    int          ptr;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;

  // bench model state
  logic [31:0] m_hi [N];
  logic [31:0] m_lo [N];
  logic [31:0] m_shi = '0;
  logic [31:0] m_fa = '0;
  int          m_cnt = 0;
  int          m_wrap = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] size_mask(input logic [31:0] lo);
    if (lo[7] && lo[4]) return 32'hFFF0_0000;
    if (lo[7])          return 32'hFFFF_0000;
    if (lo[4])          return 32'hFFFF_F000;
    return 32'hFFFF_FC00;
  endfunction

  // monitor: pop expected items as responses arrive
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R12", "unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t  e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(rsp_paddr == e.pa, t, "paddr", rsp_paddr, e.pa);
        check(rsp_fault == e.flt, t, "fault code", {28'd0, rsp_fault}, {28'd0, e.flt});
        check(fault_addr == e.fa, "R9", "fault_addr", fault_addr, e.fa);
        check(stage_hi == e.shi, "R9", "stage_hi", stage_hi, e.shi);
        check(int'(repl_ptr) == e.ptr, "R10", "repl_ptr", {26'd0, repl_ptr}, e.ptr);
      end
    end
  end

  task automatic do_req(input logic [31:0] va, input bit wr, input bit pv, input string tag);
    exp_t e;
    bit   look;
    int   nh;
    int   idx;
    logic [31:0] lo;
    logic [31:0] msk;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_priv = pv;
    e.pa = '0; e.flt = 4'd0; look = 0;
    if (va[31] && pv && va >= 32'hE000_0000)      e.pa = va;
    else if (va[31] && pv && va < 32'hC000_0000)  e.pa = va & 32'h1FFF_FFFF;
    else if (va[31] && !pv) begin
      if (va >= 32'hE000_0000 && va < 32'hE400_0000 && !cfg_sq_lock) e.pa = va;
      else e.flt = wr ? 4'd2 : 4'd1;
    end
    else if (!cfg_xlat_en) e.pa = va & 32'h1FFF_FFFF;
    else look = 1;
    if (look) begin
      nh = 0; idx = 0;
      for (int i = 0; i < N; i++) begin
        msk = size_mask(m_lo[i]);
        if (m_lo[i][8] && (m_lo[i][1] || (cfg_single_virt && pv) || m_hi[i][7:0] == m_shi[7:0])
            && ((va ^ m_hi[i]) & msk) == 32'h0) begin
          nh++; idx = i;
        end
      end
      m_cnt = m_cnt + 1;
      if (m_cnt == m_wrap || m_cnt == N) m_cnt = 0;
      if (nh == 0)      e.flt = wr ? 4'd4 : 4'd3;
      else if (nh > 1)  e.flt = 4'd8;
      else begin
        lo = m_lo[idx];
        msk = size_mask(lo);
        if (!wr && !pv && !lo[6])                 e.flt = 4'd5;
        else if (wr && pv && !lo[5])              e.flt = 4'd6;
        else if (wr && !pv && !(lo[5] && lo[6]))  e.flt = 4'd6;
        else if (wr && !lo[2])                    e.flt = 4'd7;
        else e.pa = va ^ ((va ^ (lo & 32'h1FFF_FC00)) & msk);
      end
      if (e.flt >= 4'd3) begin
        m_fa  = va;
        m_shi = {va[31:10], m_shi[9:0]};
      end
    end
    e.fa = m_fa; e.shi = m_shi; e.ptr = m_cnt;
    expq.push_back(e);
    tagq.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_hi(input logic [31:0] v);
    @(negedge clk);
    hi_we = 1'b1; hi_wdata = v;
    @(negedge clk);
    hi_we = 1'b0;
    m_shi = v;
  endtask

  // R11: stage both registers, then load at the replacement pointer
  task automatic load_entry(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    hi_we = 1'b1; hi_wdata = hi; lo_we = 1'b1; lo_wdata = lo;
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0; load_cmd = 1'b1;
    @(negedge clk);
    load_cmd = 1'b0;
    m_hi[m_cnt] = hi; m_lo[m_cnt] = lo; m_shi = hi;
    check(stage_hi == hi, "R11", "staging-high after load", stage_hi, hi);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_hi[i] = '0; m_lo[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(rsp_valid == 1'b0, "R12", "rsp_valid at reset", {31'd0, rsp_valid}, 32'd0);
    check(repl_ptr == '0, "R10", "repl_ptr at reset", {26'd0, repl_ptr}, 32'd0);
    check(fault_addr == '0, "R9", "fault_addr at reset", fault_addr, 32'd0);
    check(stage_hi == '0, "R9", "stage_hi at reset", stage_hi, 32'd0);

    // translation off, region handling
    do_req(32'h1234_5678, 0, 0, "R3");
    do_req(32'hF234_5678, 0, 1, "R1");
    do_req(32'hA000_0010, 1, 1, "R1");
    do_req(32'hD000_0020, 0, 1, "R3");
    do_req(32'hE3FF_FFF0, 0, 0, "R2");
    do_req(32'hE400_0000, 0, 0, "R2");
    do_req(32'h8000_0000, 1, 0, "R2");
    cfg_sq_lock = 1'b1;
    do_req(32'hE000_0000, 1, 0, "R2");
    cfg_sq_lock = 1'b0;

    // translation on; build the table, misses step the pointer
    cfg_xlat_en = 1'b1;
    load_entry(32'h0040_0005, 32'hEC00_0174);   // slot 0: 4K, user+wr+dirty, asid 5
    do_req(32'h7000_0000, 0, 1, "R8");
    load_entry(32'h1000_0009, 32'h0030_0192);   // slot 1: 1M shared, no user/wr
    do_req(32'h7000_0400, 1, 1, "R8");
    load_entry(32'h2000_0007, 32'h0100_01A0);   // slot 2: 64K, wr, clean, asid 7
    do_req(32'h7000_0800, 0, 0, "R8");
    load_entry(32'h3000_0005, 32'h0000_0504);   // slot 3: 1K dirty
    do_req(32'h7000_0C00, 0, 1, "R8");
    load_entry(32'h3000_0005, 32'h0000_0904);   // slot 4: same page again
    set_hi(32'h0000_0005);

    do_req(32'h0040_0ABC, 0, 0, "R5");   // R11 frame bits 31:29 dropped
    do_req(32'h0040_0FFC, 1, 0, "R5");
    set_hi(32'h0000_0306);
    do_req(32'h0040_0ABC, 0, 0, "R4");   // ASID mismatch, low bits kept (R9)
    set_hi(32'h0000_0005);
    do_req(32'h1012_3456, 0, 0, "R6");
    do_req(32'h1012_3456, 0, 1, "R4");   // shared page
    do_req(32'h1012_3456, 1, 1, "R6");
    do_req(32'h0040_0ABC, 1, 1, "R6");   // privileged write to writable page passes
    do_req(32'h2000_1234, 0, 1, "R4");
    cfg_single_virt = 1'b1;
    do_req(32'h2000_1234, 0, 1, "R4");
    do_req(32'h2000_1234, 0, 0, "R4");
    do_req(32'h2000_1234, 1, 1, "R7");
    cfg_single_virt = 1'b0;
    do_req(32'h3000_0100, 0, 1, "R8");
    do_req(32'h3000_0100, 1, 0, "R8");

    // R10: programmable boundary, then entry count
    cfg_wrap = 6'd20; m_wrap = 20;
    for (int k = 0; k < 25; k++) do_req(32'h7100_0000, 0, 1, "R10");
    cfg_wrap = 6'd0; m_wrap = 0;
    for (int k = 0; k < 70; k++) do_req(32'h7200_0000, 1, 1, "R10");

    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R12", "responses outstanding", expq.size(), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule